// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier with Power Walker

This block multiplies two 12-bit symbols of GF(4096). The field is built in two layers. The lower layer is GF(64), reduced by x^6+x+1. The upper layer is a quadratic extension over it. Each operand is split into a 6-bit upper half and a 6-bit lower half. The product is then formed from four GF(64) products and a few XORs, with no degree-12 polynomial reduction at any point.

A select input switches the same datapath to a generator step. In that mode the input symbol is multiplied by the fixed constant 0xE01, and a zero symbol is mapped to 1. A Reed-Solomon code with 12-bit symbols, first consecutive root 0, root spacing 1 and 8 roots uses this step to build its non-canonical log/antilog tables.

The table build is supported by a sequential walker. After a start pulse it emits successive powers of the generator, one per cycle, and then raises a done flag.

Top module: `gf4k_tower_unit`

## Requirements
- R1: When both operands have zero upper halves (bits 11:6), the result equals the GF(64) product of the lower halves under modulus x^6+x+1, in bits 5:0, and bits 11:6 are zero.
- R2: With op_sel=0, out_prod = {hi, lo}. Here hi = (ah^al)*(bh^bl) ^ al*bl and lo = (ah*bh)*0x21 ^ al*bl. Every * is a GF(64) product, and ah/al are bits 11:6 / 5:0 of op_a (bh/bl of op_b).
- R3: With op_sel=1, op_b is ignored. An op_a of 0 gives 0x001, and any other op_a gives op_a multiplied by 0xE01 as in R2.
- R4: With the output register enabled (default), out_valid and out_prod appear one clock after in_valid/operands are sampled. out_valid is low in any cycle after one with in_valid low.
- R5: A zero operand gives product 0, and 0x001 is the multiplicative identity.
- R6: A walk_start pulse while idle makes walk_valid high for exactly 4095 consecutive cycles. The first walk_elem is 0x001, and each following one is the previous multiplied by 0xE01.
- R7: walk_done rises in the cycle after the last element and stays high until the next accepted walk_start. A walk_start during a walk is ignored, and the sequence continues unchanged.
- R8: During reset out_valid, walk_valid and walk_done are low, and out_prod and walk_elem are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_sel | input | 1 | 0 = multiply, 1 = generator step on op_a |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand (multiply only) |
| out_valid | output | 1 | Result strobe |
| out_prod | output | 12 | Product or step result |
| walk_start | input | 1 | Starts a power walk when idle |
| walk_valid | output | 1 | Walk element present |
| walk_elem | output | 12 | Current generator power |
| walk_done | output | 1 | Walk finished |

## Verification
The assertions assume that operands are stable around the sampling edge and that walk_start is a synchronous pulse. They also rely on the step constant being nonzero and different from 1, so consecutive walk elements are nonzero and never repeat. The stimulus drives every input only on the falling clock edge. It sweeps every op_a against a fixed set of op_b values, including 0, 1 and the step constant. It covers all 4096 lower-half pairs and all 4096 step inputs, and it issues one deliberately early walk_start during a walk.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;
    localparam int          HALF_W   = 6;
    localparam int          FULL_W   = 2 * HALF_W;
    localparam logic [HALF_W-1:0] RED_TAIL = 6'h03;   // x^6 = x + 1
    localparam logic [HALF_W-1:0] TWIST    = 6'h21;   // extension constant
    localparam logic [FULL_W-1:0] STEP_K   = 12'hE01; // generator step
    localparam int          WALK_LEN = (1 << FULL_W) - 1;
    localparam int          CNT_W    = $clog2(WALK_LEN);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [FULL_W-1:0] elem;
        logic [CNT_W-1:0]  cnt;
    } walk_state_t;

    typedef struct packed {
        logic              vld;
        logic [FULL_W-1:0] prod;
    } mul_state_t;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
    parameter int          W    = 6,
    parameter logic [W-1:0] TAIL = 6'h03
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    logic [W-1:0] acc;
    logic [W-1:0] sh;

    always_comb begin
        acc = '0;
        sh  = b;
        for (int i = 0; i < W; i++) begin
            if (a[i]) acc = acc ^ sh;
            sh = {sh[W-2:0], 1'b0} ^ (sh[W-1] ? TAIL : '0);
        end
        p = acc;
    end
endmodule

// File: rtl/gf4k_tower_mul.sv
module gf4k_tower_mul
    import gf4k_pkg::*;
(
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    output logic [FULL_W-1:0] p
);
    logic [HALF_W-1:0] ah, al, bh, bl;
    logic [HALF_W-1:0] m_sum, m_low, m_high, m_twist;

    assign ah = a[FULL_W-1:HALF_W];
    assign al = a[HALF_W-1:0];
    assign bh = b[FULL_W-1:HALF_W];
    assign bl = b[HALF_W-1:0];

    gf64_mul #(.W(HALF_W), .TAIL(RED_TAIL)) u_sum   (.a(ah ^ al), .b(bh ^ bl), .p(m_sum));
    gf64_mul #(.W(HALF_W), .TAIL(RED_TAIL)) u_low   (.a(al),      .b(bl),      .p(m_low));
    gf64_mul #(.W(HALF_W), .TAIL(RED_TAIL)) u_high  (.a(ah),      .b(bh),      .p(m_high));
    gf64_mul #(.W(HALF_W), .TAIL(RED_TAIL)) u_twist (.a(m_high),  .b(TWIST),   .p(m_twist));

    assign p = {m_sum ^ m_low, m_twist ^ m_low};
endmodule

// File: rtl/gf4k_walker.sv
module gf4k_walker
    import gf4k_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              valid,
    output logic [FULL_W-1:0] elem,
    output logic              done
);
    walk_state_t       st_d, st_q;
    logic [FULL_W-1:0] next_elem;

    gf4k_tower_mul u_step (.a(st_q.elem), .b(STEP_K), .p(next_elem));

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.elem = next_elem;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(WALK_LEN - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.elem = '0;
                st_d.cnt  = '0;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
            st_d.elem = FULL_W'(1);
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.busy;
    assign elem  = st_q.elem;
    assign done  = st_q.done;

    // R6
    walk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> elem != '0);
    // R6
    walk_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && $past(valid) |-> elem != $past(elem));
    // R7
    walk_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));
    // R7
    walk_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> done);
endmodule

// File: rtl/gf4k_tower_unit.sv
module gf4k_tower_unit
    import gf4k_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sel,
    input  logic [FULL_W-1:0] op_a,
    input  logic [FULL_W-1:0] op_b,
    output logic              out_valid,
    output logic [FULL_W-1:0] out_prod,
    input  logic              walk_start,
    output logic              walk_valid,
    output logic [FULL_W-1:0] walk_elem,
    output logic              walk_done
);
    logic [FULL_W-1:0] b_eff;
    logic [FULL_W-1:0] prod_c;
    logic [FULL_W-1:0] res_c;

    assign b_eff = op_sel ? STEP_K : op_b;

    gf4k_tower_mul u_mul (.a(op_a), .b(b_eff), .p(prod_c));

    assign res_c = (op_sel && op_a == '0) ? FULL_W'(1) : prod_c;

    generate
        if (OUT_REG) begin : g_reg
            mul_state_t ms_d, ms_q;

            always_comb begin
                ms_d.vld  = in_valid;
                ms_d.prod = in_valid ? res_c : ms_q.prod;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ms_q <= '0;
                else        ms_q <= ms_d;
            end

            assign out_valid = ms_q.vld;
            assign out_prod  = ms_q.prod;

            // R4
            out_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R4
            out_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R5
            zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && !op_sel && (op_a == '0 || op_b == '0) |=> out_prod == '0);
            // R3
            step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && op_sel && op_a == '0 |=> out_prod == FULL_W'(1));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_prod  = res_c;
        end
    endgenerate

    gf4k_walker u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (walk_start),
        .valid (walk_valid),
        .elem  (walk_elem),
        .done  (walk_done)
    );
endmodule

// File: tb/gf4k_tower_unit_tb.sv
module gf4k_tower_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic        out_valid;
    logic [11:0] out_prod;
    logic        walk_start = 1'b0;
    logic        walk_valid;
    logic [11:0] walk_elem;
    logic        walk_done;

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;

    always #2 clk = ~clk;

    gf4k_tower_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_prod(out_prod),
        .walk_start(walk_start), .walk_valid(walk_valid),
        .walk_elem(walk_elem), .walk_done(walk_done)
    );

    function automatic logic [5:0] m64(input logic [5:0] a, input logic [5:0] b);
        logic [10:0] p = '0;
        for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
        for (int k = 10; k >= 6; k--) if (p[k]) p = p ^ (11'h43 << (k - 6));
        return p[5:0];
    endfunction

    function automatic logic [11:0] m4k(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] hi, lo;
        hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
        lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
        return {hi, lo};
    endfunction

    task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic vec(input string req, input logic sel, input logic [11:0] a,
                       input logic [11:0] b, input logic [11:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op_sel = sel; op_a = a; op_b = b;
        @(negedge clk);
        chk({req, " valid"}, {11'd0, out_valid}, 12'd1);
        chk(req, out_prod, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                nbad++;
                $display("FAIL watchdog got %0d expected <190000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
                $finish;
            end
        end
    end

    initial begin
        logic [11:0] bset [7] = '{12'h000, 12'h001, 12'h03F, 12'h040, 12'hE01, 12'hFFF, 12'h5A3};
        logic [11:0] e;

        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 out_valid", {11'd0, out_valid}, 12'd0);
        chk("R8 out_prod", out_prod, 12'd0);
        chk("R8 walk_valid", {11'd0, walk_valid}, 12'd0);
        chk("R8 walk_done", {11'd0, walk_done}, 12'd0);
        chk("R8 walk_elem", walk_elem, 12'd0);
        rst_n = 1'b1;

        // R1 all lower-half pairs
        for (int x = 0; x < 64; x++)
            for (int y = 0; y < 64; y++)
                vec("R1", 1'b0, 12'(x), 12'(y), {6'd0, m64(6'(x), 6'(y))});

        // R2 / R5 full sweep of op_a against fixed op_b set
        for (int j = 0; j < 7; j++)
            for (int x = 0; x < 4096; x++) begin
                if (bset[j] == 12'h000)      vec("R5 zero",     1'b0, 12'(x), bset[j], 12'h000);
                else if (bset[j] == 12'h001) vec("R5 identity", 1'b0, 12'(x), bset[j], 12'(x));
                else                         vec("R2",          1'b0, 12'(x), bset[j], m4k(12'(x), bset[j]));
            end
        // R5 zero on the left operand
        vec("R5 zero left", 1'b0, 12'h000, 12'hABC, 12'h000);

        // R3 generator step, op_b toggled to show it is ignored
        for (int x = 0; x < 4096; x++)
            vec("R3", 1'b1, 12'(x), ~12'(x), (x == 0) ? 12'h001 : m4k(12'(x), 12'hE01));

        // R4 out_valid drops one cycle after in_valid drops
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk("R4 drop", {11'd0, out_valid}, 12'd0);

        // R6 / R7 power walk with an ignored mid-walk start
        @(negedge clk); walk_start = 1'b1;
        @(negedge clk); walk_start = 1'b0;
        e = 12'h001;
        for (int k = 0; k < 4095; k++) begin
            chk("R6 walk_valid", {11'd0, walk_valid}, 12'd1);
            chk("R6 walk_elem", walk_elem, e);
            e = m4k(e, 12'hE01);
            walk_start = (k == 100); // R7 ignored while busy
            @(negedge clk);
        end
        walk_start = 1'b0;
        chk("R7 walk ended", {11'd0, walk_valid}, 12'd0);
        chk("R7 done", {11'd0, walk_done}, 12'd1);
        repeat (3) @(negedge clk);
        chk("R7 done held", {11'd0, walk_done}, 12'd1);
        walk_start = 1'b1;
        @(negedge clk); walk_start = 1'b0;
        chk("R7 done cleared", {11'd0, walk_done}, 12'd0);
        chk("R7 restart", walk_elem, 12'h001);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule